// File: doc/BRIEF.md
# Multicore Run and Wake Controller

This block keeps the run or halt state of a fixed number of CPU cores and delivers inter-processor interrupts to them. When reset is released, only core 0 is allowed to run. Every other core waits until another agent sends it an IPI. An IPI names a core by its binary index. It marks an interrupt as pending for that core and also sets the core's run enable. A global stop request drops the run enable of every core at once. Each core can halt itself, and each core clears its pending interrupt with an acknowledge strobe.

Each core samples its run enable only between instructions. A core therefore finishes the instruction in progress before a halt or stop takes effect. The block updates all outputs on the clock edge after a request. It has no buffering: a request counts in the cycle it is presented.

Top module: `core_wake_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `run_en` has only bit 0 set (core 0 runs, all others are halted).
- R2: During reset and in the first cycle after it, every bit of `irq_pend` is 0.
- R3: An IPI with `ipi_target` below NUM_CORES sets bit `ipi_target` of `irq_pend` on the next clock edge.
- R4: An IPI with `ipi_target` below NUM_CORES sets bit `ipi_target` of `run_en` on the next clock edge, provided no stop request is active. This holds even if that core raises its halt request in the same cycle.
- R5: An IPI whose `ipi_target` is NUM_CORES or higher changes neither `run_en` nor `irq_pend`.
- R6: A stop request clears every bit of `run_en` on the next clock edge. It overrides an IPI wake in the same cycle, although that IPI still sets its pending bit.
- R7: When `halt_req[i]` is high with no stop and no IPI to core i, `run_en[i]` is 0 after the next clock edge.
- R8: When `pend_ack[i]` is high, `irq_pend[i]` is 0 after the next clock edge, unless an IPI to core i arrives in the same cycle. In that case the set wins and the bit stays 1.
- R9: A core that receives no request in a cycle keeps its `run_en` and `irq_pend` bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ipi_valid | input | 1 | An IPI request is presented this cycle |
| ipi_target | input | IDX_W | Binary index of the target core |
| stop_req | input | 1 | Global stop: halt every core |
| halt_req | input | NUM_CORES | Bit i: core i requests its own halt |
| pend_ack | input | NUM_CORES | Bit i: core i acknowledges its pending interrupt |
| run_en | output | NUM_CORES | Bit i: core i may execute |
| irq_pend | output | NUM_CORES | Bit i: interrupt pending for core i |

## Verification
Each core's state sits in one register pair that drives the ports directly. A corrupted run or pending bit therefore shows on `run_en` or `irq_pend` one cycle after the stimulus that set it, and stays there until a later request overwrites it. The bench predicts both vectors every cycle, so a wrong bit is caught on the cycle it appears. The same check catches a wrong bit on a core that received no request. The cases that count most are the same-cycle conflicts: IPI against halt, IPI against acknowledge, and stop against IPI. The out-of-range indices matter too, because a faulty decode there would wake a real core.

// File: rtl/wake_pkg.sv
// Package: shared helper for the core wake controller.
// Assumes: core counts from 1 to 8.
package wake_pkg;
    // Width of a binary core index, at least one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/ipi_decode.sv
// Module: turns an IPI request into a one-hot per-core hit vector.
// Assumes: target is binary; an index with no matching core yields no hit,
// so an out-of-range request is dropped without any extra range check.
module ipi_decode #(
    parameter int NUM_CORES = 6,
    parameter int IDX_W     = 3
) (
    input  logic                 valid,
    input  logic [IDX_W-1:0]     target,
    output logic [NUM_CORES-1:0] hit
);
    // One comparator per existing core.
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_cmp
        assign hit[i] = valid && (target == IDX_W'(i));
    end
endmodule

// File: rtl/core_slot.sv
// Module: run and pending state of a single core.
// Assumes: wake is already qualified for this core.
// Run priority: stop, then wake, then halt.
// Pending priority: set by wake, then clear by ack.
module core_slot #(
    parameter bit RESET_RUN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic wake,
    input  logic halt,
    input  logic ack,
    output logic run_q,
    output logic pend_q
);
    // Run flag: global stop dominates, an IPI wake beats a self halt.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= RESET_RUN;
        else if (stop)  run_q <= 1'b0;
        else if (wake)  run_q <= 1'b1;
        else if (halt)  run_q <= 1'b0;
    end

    // Pending flag: a new IPI wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (wake)  pend_q <= 1'b1;
        else if (ack)   pend_q <= 1'b0;
    end
endmodule

// File: rtl/core_wake_ctrl.sv
// Module: top of the multicore run and wake controller.
// Decodes IPIs and keeps one state slot per core. Core 0 leaves reset running.
// Assumes: synchronous active-low reset; NUM_CORES from 1 to 8.
module core_wake_ctrl #(
    parameter int NUM_CORES = 6,
    parameter int IDX_W     = wake_pkg::idx_width(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ipi_valid,
    input  logic [IDX_W-1:0]     ipi_target,
    input  logic                 stop_req,
    input  logic [NUM_CORES-1:0] halt_req,
    input  logic [NUM_CORES-1:0] pend_ack,
    output logic [NUM_CORES-1:0] run_en,
    output logic [NUM_CORES-1:0] irq_pend
);
    logic [NUM_CORES-1:0] hit;

    // Decode of the IPI target.
    ipi_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_dec (
        .valid  (ipi_valid),
        .target (ipi_target),
        .hit    (hit)
    );

    // One state slot per core; only slot 0 resets to running.
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        core_slot #(.RESET_RUN(i == 0)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .stop   (stop_req),
            .wake   (hit[i]),
            .halt   (halt_req[i]),
            .ack    (pend_ack[i]),
            .run_q  (run_en[i]),
            .pend_q (irq_pend[i])
        );
    end
endmodule

// File: rtl/core_wake_ctrl_chk.sv
// Checker: temporal properties of the wake controller at its ports.
module core_wake_ctrl_chk #(
    parameter int NUM_CORES = 6,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ipi_valid,
    input logic [IDX_W-1:0]     ipi_target,
    input logic                 stop_req,
    input logic [NUM_CORES-1:0] halt_req,
    input logic [NUM_CORES-1:0] pend_ack,
    input logic [NUM_CORES-1:0] run_en,
    input logic [NUM_CORES-1:0] irq_pend
);
    localparam logic [IDX_W:0] CNT = (IDX_W+1)'(NUM_CORES);
    localparam logic [NUM_CORES-1:0] BOOT = NUM_CORES'(1);
    logic in_rng;
    assign in_rng = ({1'b0, ipi_target} < CNT);

    AST_RESET_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> run_en == BOOT);                                   // R1
    AST_RESET_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> irq_pend == '0);                                   // R2
    AST_IPI_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_valid && in_rng |=> irq_pend[$past(ipi_target)]);                // R3
    AST_IPI_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_valid && in_rng && !stop_req |=> run_en[$past(ipi_target)]);     // R4
    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_valid && !in_rng && !stop_req && halt_req == '0 && pend_ack == '0
        |=> $stable(run_en) && $stable(irq_pend));                           // R5
    AST_STOP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> run_en == '0);                                          // R6
    AST_SELF_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req != '0 && !ipi_valid && !stop_req
        |=> (run_en & $past(halt_req)) == '0);                               // R7
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pend_ack != '0 && !ipi_valid
        |=> (irq_pend & $past(pend_ack)) == '0);                             // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ipi_valid && !stop_req && halt_req == '0 && pend_ack == '0
        |=> $stable(run_en) && $stable(irq_pend));                           // R9
endmodule

bind core_wake_ctrl core_wake_ctrl_chk #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ipi_valid  (ipi_valid),
    .ipi_target (ipi_target),
    .stop_req   (stop_req),
    .halt_req   (halt_req),
    .pend_ack   (pend_ack),
    .run_en     (run_en),
    .irq_pend   (irq_pend)
);

// File: tb/sim_core_wake_ctrl.sv
// Bench: scoreboard. The driver applies one request set per cycle and queues
// the expected outputs. The monitor pops and compares after each rising edge.
module sim_core_wake_ctrl;
    localparam int N      = 6;
    localparam int W      = 3;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ipi_valid = 1'b0;
    logic [W-1:0] ipi_target = '0;
    logic         stop_req = 1'b0;
    logic [N-1:0] halt_req = '0;
    logic [N-1:0] pend_ack = '0;
    logic [N-1:0] run_en;
    logic [N-1:0] irq_pend;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [N-1:0] m_run, m_pend;
    logic [N-1:0] q_run[$];
    logic [N-1:0] q_pend[$];
    string        q_tag[$];

    always #(PERIOD/2) clk = ~clk;

    core_wake_ctrl #(.NUM_CORES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ipi_valid(ipi_valid), .ipi_target(ipi_target),
        .stop_req(stop_req), .halt_req(halt_req), .pend_ack(pend_ack),
        .run_en(run_en), .irq_pend(irq_pend)
    );

    task automatic compare(input string tag, input logic [N-1:0] act_r,
                           input logic [N-1:0] exp_r, input logic [N-1:0] act_p,
                           input logic [N-1:0] exp_p);
        checks++;
        if (act_r !== exp_r) begin
            errors++;
            $display("FAIL %s run_en actual=%b expected=%b", tag, act_r, exp_r);
        end
        checks++;
        if (act_p !== exp_p) begin
            errors++;
            $display("FAIL %s irq_pend actual=%b expected=%b", tag, act_p, exp_p);
        end
    endtask

    // Driver: apply one cycle of requests, update the model, queue the result.
    task automatic apply(input bit iv, input int tgt, input bit stp,
                         input logic [N-1:0] hlt, input logic [N-1:0] ack,
                         input string tag);
        logic [N-1:0] hit;
        @(negedge clk);
        ipi_valid  = iv;
        ipi_target = W'(tgt);
        stop_req   = stp;
        halt_req   = hlt;
        pend_ack   = ack;
        hit = '0;
        if (iv && tgt < N) hit[tgt] = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (stp)         m_run[i] = 1'b0;
            else if (hit[i]) m_run[i] = 1'b1;
            else if (hlt[i]) m_run[i] = 1'b0;
            if (hit[i])      m_pend[i] = 1'b1;
            else if (ack[i]) m_pend[i] = 1'b0;
        end
        q_run.push_back(m_run);
        q_pend.push_back(m_pend);
        q_tag.push_back(tag);
    endtask

    // Monitor: one quarter period after each rising edge, check the oldest entry.
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (q_run.size() > 0)
                compare(q_tag.pop_front(), run_en, q_run.pop_front(),
                        irq_pend, q_pend.pop_front());
        end
    end

    initial begin
        #(PERIOD*5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog run_en actual=%b expected=idle", run_en);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_run  = N'(1);
        m_pend = '0;
        repeat (3) @(negedge clk);
        compare("R1 R2 during reset", run_en, N'(1), irq_pend, '0);
        rst_n = 1'b1;
        @(posedge clk);
        #(PERIOD/4);
        compare("R1 R2 after reset", run_en, N'(1), irq_pend, '0);

        apply(0, 0, 0, '0, '0, "R9 idle");
        apply(1, 2, 0, '0, '0, "R3 R4 ipi core 2");
        apply(1, 5, 0, '0, '0, "R3 R4 ipi top core 5");
        apply(1, 6, 0, '0, '0, "R5 index 6 ignored");
        apply(1, 7, 0, '0, '0, "R5 index 7 ignored");
        apply(0, 0, 0, 6'b000100, '0, "R7 core 2 halts");
        apply(1, 0, 0, 6'b000001, '0, "R4 wake beats halt core 0");
        apply(0, 0, 0, '0, 6'b000100, "R8 ack core 2");
        apply(1, 5, 0, '0, 6'b100000, "R8 ipi wins over ack core 5");
        apply(1, 3, 0, 6'b100001, 6'b100000, "R4 R7 R8 mixed");
        apply(1, 1, 1, '0, '0, "R6 stop over ipi core 1");
        apply(0, 0, 0, '0, '0, "R9 hold after stop");
        apply(1, 4, 0, '0, 6'b111111, "R3 R4 R8 wake after stop");
        apply(1, 6, 0, 6'b010000, '0, "R5 R7 ignored ipi with halt");
        apply(0, 0, 1, '0, '0, "R6 stop");
        apply(0, 0, 0, '0, '0, "R9 idle end");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule